// File: doc/BRIEF.md
# Two-Dimensional Chained DMA Sequencer

This block is the address and sequencing core of one DMA channel. It walks a rectangular pattern through memory: an inner run of elements spaced by a signed inner stride, repeated for a number of rows, with a signed outer stride applied between rows. With this pattern a tile can be lifted out of a frame that is stored linearly, or a tile can be written back into one. Each element moves over a memory request/acknowledge port. A peripheral paces the elements with a request/grant handshake, and the element data passes straight through between the peripheral and the memory port.

A work unit can be set up in two ways. In the first, software writes the shadow registers and starts the channel directly. The channel then either stops after one unit or, in repeat mode, reloads its working state from the shadow registers and runs the unit again until it is aborted. In the second, the channel reads a nine-word parameter block from memory. The block names the next parameter block, so work units can be chained with no software involvement between them. A one-cycle interrupt can mark the end of each unit, and a count of zero is reported as an error.

Top module: `dma2d_engine`

## Requirements
- R1: After reset `busy`, `irq` and `err` are low and no memory request is made until a start.
- R2: A unit of X count `xc` and Y count `yc` makes exactly `xc*yc` element accesses. The first is at the start address. After each element the address adds the sign-extended 16-bit inner stride, except after the last element of a row, where it adds the sign-extended outer stride instead.
- R3: An element goes ahead only while `per_req` is high. `per_gnt` is high exactly in the cycle in which `mem_ack` answers an element request. `mem_we` follows direction bit 4 of the config (1 = write `per_wdata` to memory).
- R4: Writing the control register (address 1) with bit 0 set starts the channel. Bit 1 selects descriptor mode. In register mode with repeat bit 2 clear, the channel makes one unit and then drops `busy`.
- R5: In register mode with bit 2 set, the channel reloads the shadow start address, counts and strides at the end of each unit and repeats the same address sequence.
- R6: `irq` is a one-cycle pulse, given one cycle after the last element of a unit, and only when config bit 3 is set.
- R7: A zero X or Y count sets `err`, makes no element access and returns the channel to idle. The next start clears `err`.
- R8: In descriptor mode the channel reads nine 16-bit words at pointer+0, +2, … +16, in this order: next-pointer low, start low, start high, config, X count, X stride, Y count, Y stride, next-pointer high.
- R9: At the end of a descriptor unit, if bit 1 of the fetched config is set, the channel fetches the next block at {high,low} of the next pointer. Otherwise it goes idle.
- R10: Writing the control register with bit 0 clear aborts the channel to idle in the next cycle. A start written while the channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 start, 1 control, 2 X count, 3 X stride, 4 Y count, 5 Y stride, 6 descriptor pointer |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| per_req | input | 1 | Peripheral asks for an element |
| per_gnt | output | 1 | Element completes this cycle |
| per_wdata | input | 16 | Element data from the peripheral |
| per_rdata | output | 16 | Element data to the peripheral |
| busy | output | 1 | Channel active |
| irq | output | 1 | End-of-unit pulse |
| err | output | 1 | Zero-count error, sticky until next start |

## Verification
The bench sweeps small X and Y counts with positive and negative strides, with memory stalls and peripheral gaps. An engine that applied the inner stride at a row end, or that dropped a row or an element, would produce an address list that differs from the arithmetic one. Chained descriptors check the fetch order and the 32-bit reassembly of the pointer and the start address: if the halves were swapped, the fetch and element addresses would land elsewhere. A zero count must give an error with no accesses at all. An engine that started anyway would show stray grants. Repeat mode must reproduce the same sequence each time and must ignore a start written while busy, or the interrupts would stop.

// File: rtl/dma2d_engine.sv
module dma2d_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  input  logic        per_req,
  output logic        per_gnt,
  input  logic [15:0] per_wdata,
  output logic [15:0] per_rdata,
  output logic        busy,
  output logic        irq,
  output logic        err
);
  typedef enum logic [1:0] {IDLE, FETCH, CHECK, XFER} st_t;
  st_t st;

  logic [31:0] s_start, s_ptr, addr, dptr, nxt;
  logic [15:0] s_xc, s_xm, s_yc, s_ym;
  logic [15:0] xc, xm, ym, xr, yr, plo;
  logic [4:1]  cfg;
  logic [3:0]  idx;
  logic        dmode;

  wire ctl_wr  = cfg_we && cfg_addr == 3'd1;
  wire start_w = ctl_wr && cfg_wdata[0] && st == IDLE;
  wire abort_w = ctl_wr && !cfg_wdata[0];
  wire beat    = st == XFER && mem_req && mem_ack;
  wire row_end = xr == 16'd1;
  wire last    = row_end && yr == 16'd1;

  assign mem_req   = st == FETCH || (st == XFER && per_req);
  assign mem_we    = st == XFER && cfg[4];
  assign mem_addr  = st == FETCH ? dptr + {27'd0, idx, 1'b0} : addr;
  assign mem_wdata = per_wdata;
  assign per_rdata = mem_rdata;
  assign per_gnt   = beat;
  assign busy      = st != IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; irq <= 1'b0; err <= 1'b0; dmode <= 1'b0; idx <= '0;
      s_start <= '0; s_ptr <= '0; s_xc <= '0; s_xm <= '0; s_yc <= '0; s_ym <= '0;
      addr <= '0; dptr <= '0; nxt <= '0; plo <= '0; cfg <= '0;
      xc <= '0; xm <= '0; ym <= '0; xr <= '0; yr <= '0;
    end else begin
      irq <= 1'b0;
      if (cfg_we)
        case (cfg_addr)
          3'd0: s_start <= cfg_wdata;
          3'd2: s_xc    <= cfg_wdata[15:0];
          3'd3: s_xm    <= cfg_wdata[15:0];
          3'd4: s_yc    <= cfg_wdata[15:0];
          3'd5: s_ym    <= cfg_wdata[15:0];
          3'd6: s_ptr   <= cfg_wdata;
          default: ;
        endcase
      if (abort_w) st <= IDLE;
      else
        case (st)
          IDLE: if (start_w) begin
            err   <= 1'b0;
            dmode <= cfg_wdata[1];
            if (cfg_wdata[1]) begin
              dptr <= s_ptr; idx <= '0; st <= FETCH;
            end else begin
              cfg  <= cfg_wdata[4:1];
              addr <= s_start; xc <= s_xc; xr <= s_xc; xm <= s_xm;
              yr   <= s_yc; ym <= s_ym; st <= CHECK;
            end
          end
          FETCH: if (mem_ack) begin
            idx <= idx + 4'd1;
            case (idx)
              4'd0: plo <= mem_rdata;
              4'd1: addr[15:0] <= mem_rdata;
              4'd2: addr[31:16] <= mem_rdata;
              4'd3: cfg <= mem_rdata[4:1];
              4'd4: begin xc <= mem_rdata; xr <= mem_rdata; end
              4'd5: xm <= mem_rdata;
              4'd6: yr <= mem_rdata;
              4'd7: ym <= mem_rdata;
              default: begin nxt <= {mem_rdata, plo}; st <= CHECK; end
            endcase
          end
          CHECK:
            if (xr == '0 || yr == '0) begin err <= 1'b1; st <= IDLE; end
            else st <= XFER;
          XFER: if (beat) begin
            if (row_end) begin
              addr <= addr + {{16{ym[15]}}, ym}; xr <= xc; yr <= yr - 16'd1;
            end else begin
              addr <= addr + {{16{xm[15]}}, xm}; xr <= xr - 16'd1;
            end
            if (last) begin
              irq <= cfg[3];
              if (dmode) begin
                if (cfg[1]) begin dptr <= nxt; idx <= '0; st <= FETCH; end
                else st <= IDLE;
              end else if (cfg[2]) begin
                addr <= s_start; xc <= s_xc; xr <= s_xc; xm <= s_xm;
                yr   <= s_yc; ym <= s_ym; st <= CHECK;
              end else st <= IDLE;
            end
          end
          default: st <= IDLE;
        endcase
    end
  end
endmodule

// File: rtl/dma2d_engine_chk.sv
module dma2d_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [2:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        per_req,
  input logic        per_gnt,
  input logic        busy,
  input logic        irq,
  input logic        err
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  p_gnt_paced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per_gnt |-> (per_req && mem_req && mem_ack));
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(per_gnt));
  p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !per_gnt));
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd1 && !cfg_wdata[0]) |=> !busy);
endmodule

bind dma2d_engine dma2d_engine_chk u_chk (.*);

// File: tb/sim_dma2d_engine.sv
module sim_dma2d_engine;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic mem_req, mem_we, mem_ack, per_gnt, busy, irq, err;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, per_rdata;
  logic per_req = 1, stall = 0;
  logic [15:0] per_wdata = 16'h0;
  logic [15:0] mem [0:255];
  logic [31:0] glog [0:63];
  logic [31:0] flog [0:31];
  int gn = 0, fn = 0, nirq = 0, nwe = 0, cyc = 0;
  bit stall_en = 0, gap_en = 0;
  int ntests = 0, nfail = 0, bad = 0;

  always #5 clk = ~clk;

  dma2d_engine u0 (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .mem_req, .mem_we,
    .mem_addr, .mem_wdata, .mem_ack, .mem_rdata, .per_req, .per_gnt, .per_wdata,
    .per_rdata, .busy, .irq, .err);

  assign mem_ack   = mem_req && !stall;
  assign mem_rdata = mem[mem_addr[8:1]];
  always @(posedge clk) if (mem_req && mem_ack && mem_we) mem[mem_addr[8:1]] <= mem_wdata;

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    stall   = stall_en && (cyc % 3 == 0);
    per_req = !(gap_en && (cyc % 4 == 1));
  end

  always @(negedge clk) begin
    if (per_gnt) begin
      if (gn < 64) glog[gn] = mem_addr;
      gn++;
      if (mem_we) nwe++;
    end else if (mem_req && mem_ack) begin
      if (fn < 32) flog[fn] = mem_addr;
      fn++;
    end
    if (irq) nirq++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1 cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic clear_logs();
    gn = 0; fn = 0; nirq = 0; nwe = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic walk(input int k0, input logic [31:0] st, input int xc, input int xs,
                      input int yc, input int ys);
    logic [31:0] a = st;
    for (int y = 0; y < yc; y++)
      for (int x = 0; x < xc; x++) begin
        if (k0 + y*xc + x >= gn || glog[k0 + y*xc + x] != a) bad++;
        a = (x == xc-1) ? a + 32'(ys) : a + 32'(xs);
      end
  endtask

  task automatic setup(input logic [31:0] st, input int xc, input int xs, input int yc, input int ys);
    wr(0, st); wr(2, 32'(xc)); wr(3, 32'(16'(xs))); wr(4, 32'(yc)); wr(5, 32'(16'(ys)));
  endtask

  initial begin
    int xsv[2] = '{2, -4};
    int ysv[2] = '{8, -6};
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(!busy && !irq && !err && !mem_req, "R1 reset state", {busy, irq, err, mem_req}, 0);

    for (int xc = 1; xc <= 3; xc++)
      for (int yc = 1; yc <= 3; yc++)
        for (int i = 0; i < 2; i++)
          for (int j = 0; j < 2; j++) begin
            stall_en = (i ^ j); gap_en = (xc == 2);
            setup(32'h100 + 32'(xc*16), xc, xsv[i], yc, ysv[j]);
            clear_logs();
            wr(1, 32'h09);
            wait_idle();
            bad = 0;
            walk(0, 32'h100 + 32'(xc*16), xc, xsv[i], yc, ysv[j]);
            check(gn == xc*yc, "R2 element count", gn, xc*yc);
            check(bad == 0, "R2 address walk", bad, 0);
            check(nirq == 1, "R6 one irq per unit", nirq, 1);
            check(!busy && nwe == 0, "R4 stop mode idle, R3 read direction", {busy, 8'(nwe)}, 0);
          end
    stall_en = 0; gap_en = 0;

    setup(32'h40, 2, 2, 2, 4);
    clear_logs(); wr(1, 32'h01); wait_idle();
    check(nirq == 0, "R6 irq disabled", nirq, 0);
    check(gn == 4, "R2 count without irq", gn, 4);

    per_wdata = 16'hBEEF;
    setup(32'h40, 2, 2, 1, 2);
    clear_logs(); wr(1, 32'h19); wait_idle();
    check(nwe == 2, "R3 write direction", nwe, 2);
    check(mem[8'h20] == 16'hBEEF && mem[8'h21] == 16'hBEEF, "R3 write data",
          {mem[8'h20], mem[8'h21]}, 32'hBEEFBEEF);

    setup(32'h40, 0, 2, 2, 2);
    clear_logs(); wr(1, 32'h09); wait_idle();
    check(err == 1, "R7 zero X count error", err, 1);
    check(gn == 0 && nirq == 0 && !busy, "R7 no transfers", gn, 0);
    setup(32'h40, 2, 2, 0, 2);
    clear_logs(); wr(1, 32'h09); wait_idle();
    check(err == 1 && gn == 0, "R7 zero Y count error", {err, 8'(gn)}, 9'h100);
    setup(32'h40, 1, 2, 1, 2);
    clear_logs(); wr(1, 32'h09); wait_idle();
    check(err == 0 && gn == 1, "R7 error cleared by start", {err, 8'(gn)}, 1);

    stall_en = 1;
    setup(32'h80, 2, 2, 2, 4);
    clear_logs(); wr(1, 32'h0D);
    for (int n = 0; n < 500 && nirq < 1; n++) @(negedge clk);
    wr(1, 32'h01);
    for (int n = 0; n < 1000 && nirq < 3; n++) @(negedge clk);
    check(nirq >= 3 && busy, "R10 start while busy ignored, R5 repeats", nirq, 3);
    wr(1, 32'h00);
    check(!busy, "R10 abort to idle", busy, 0);
    bad = 0;
    for (int u = 0; u < 3; u++) walk(u*4, 32'h80, 2, 2, 2, 4);
    check(bad == 0, "R5 repeated sequence", bad, 0);
    stall_en = 0;

    begin
      logic [15:0] d1 [9] = '{16'h01A0, 16'h0010, 16'h0001, 16'h000A, 16'd3, 16'd2, 16'd2, 16'd10, 16'h0000};
      logic [15:0] d2 [9] = '{16'h0000, 16'h0100, 16'h0000, 16'h0008, 16'd1, 16'd0, 16'd2, 16'hFFF0, 16'h0000};
      for (int i = 0; i < 9; i++) begin mem[8'hC0 + 8'(i)] = d1[i]; mem[8'hD0 + 8'(i)] = d2[i]; end
    end
    gap_en = 1;
    wr(6, 32'h180);
    clear_logs(); wr(1, 32'h03); wait_idle();
    bad = 0;
    for (int i = 0; i < 9; i++) begin
      if (flog[i] != 32'h180 + 32'(2*i)) bad++;
      if (flog[9+i] != 32'h1A0 + 32'(2*i)) bad++;
    end
    check(fn == 18, "R8 descriptor word count", fn, 18);
    check(bad == 0, "R8 descriptor fetch order", bad, 0);
    bad = 0;
    walk(0, 32'h10010, 3, 2, 2, 10);
    walk(6, 32'h100, 1, 0, 2, -16);
    check(gn == 8 && bad == 0, "R9 chained units", bad, 0);
    check(nirq == 2 && !busy, "R9 chain end idle", nirq, 2);
    gap_en = 0;

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule